// File: doc/BRIEF.md
# Startup Reset Sequencer

This block sits between an asynchronous reset pin and a processor core. It brings the pin into the clock domain, measures how long the pin stays high, and ignores pulses that are too short to be a real reset. After a reset of valid width it holds the core stopped and floats the external bus for as long as the pin stays high. When the pin falls, the block counts through a fixed-length internal initialization and then lets the core run. On the first run cycle it gives a one-cycle start pulse along with the fixed boot address.

Around the end of reset the block also decides two things for the core. A rising edge on the asynchronous non-maskable request input is dropped if it arrives while reset is held or during the first few clocks of initialization. Otherwise it is latched until the core acknowledges it. A bus hold request that is present when initialization ends is granted before the core is released. The address, ALE and hold-acknowledge lines are forced to known levels whenever the core is not running.

Top module: `boot_sequencer`

## Requirements
- R1: The reset pin and the non-maskable request pin each pass through SYNC_STAGES flip-flops (default 2) before any decision uses them, so a pin change affects the outputs no earlier than SYNC_STAGES+1 clocks later.
- R2: A reset pulse whose synchronized high time is MIN_HIGH clocks or fewer (default 4) is ignored. A running core keeps running, and a block waiting after `sys_rst` keeps waiting.
- R3: Once the synchronized pin has been high for MIN_HIGH+1 clocks, `core_run` drops the next cycle from any state. It stays low for as long as the synchronized pin stays high.
- R4: After the synchronized pin falls following a valid pulse, exactly INIT_LEN clocks (default 10) of initialization pass before `core_run` rises. `fetch_go` is high for exactly the first run cycle, and `start_addr` always reads RESET_VEC (default 20'hFFFF0).
- R5: A synchronized rising edge of the request pin is dropped while the core is held in reset and during the first NMI_BLIND clocks (default 2) of initialization. An edge seen later in initialization, during hold or during run sets `nmi_req`. A level that was already high before the window opened never sets it.
- R6: `nmi_req` stays high until `nmi_ack` is seen, except that a new edge in the same cycle keeps it set. It is cleared whenever the core is held in reset.
- R7: `bus_float` is high in every cycle the core is not running. `stat_en` is high while running and for exactly one cycle after a valid reset stops a running core.
- R8: While the core is not running, `ale` is low and `hlda` is low except when a hold is granted. While running, `ale` follows `core_ale` and `hlda` follows `core_hlda`.
- R9: If `hold_req` is high in the last initialization clock, the block enters a hold state with `hlda` high instead of running. It releases the core, with `fetch_go`, in the cycle after `hold_req` falls.
- R10: The synchronous `sys_rst` puts the block in the held state with `core_run` low, `bus_float` high and `nmi_req` low. A valid reset pulse is needed to leave that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Synchronous active-high power-on reset of the sequencer |
| reset_pin | input | 1 | Asynchronous active-high processor reset input |
| nmi_pin | input | 1 | Asynchronous non-maskable request, rising-edge sensitive |
| nmi_ack | input | 1 | Core acknowledges the pending request |
| hold_req | input | 1 | Bus hold request (synchronous) |
| core_ale | input | 1 | Address latch enable from the core |
| core_hlda | input | 1 | Hold acknowledge from the core while running |
| core_run | output | 1 | Core may execute |
| fetch_go | output | 1 | One-cycle pulse on the first run cycle |
| start_addr | output | ADDR_W | Boot fetch address |
| nmi_req | output | 1 | Latched non-maskable request to the core |
| bus_float | output | 1 | Tri-state bus outputs released |
| stat_en | output | 1 | Status lines driven |
| ale | output | 1 | Address latch enable to the bus |
| hlda | output | 1 | Hold acknowledge to the bus |

## Verification
The hardest case to reach is a request edge that lands exactly on the boundary of the blind window. That boundary sits SYNC_STAGES+NMI_BLIND clocks after the pin falls, so the bench loops over request delays of zero to several clocks after the falling edge. A behavioural model decides, cycle by cycle, whether each edge counts. Width qualification is covered by pulses of exactly MIN_HIGH and MIN_HIGH+1 clocks, both while running and while waiting after power-on. A reset that arrives again during initialization and a hold request that is raised partway through initialization cover the other transitions.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [1:0] {
        SQ_RUN  = 2'd0,
        SQ_HALT = 2'd1,
        SQ_INIT = 2'd2,
        SQ_HOLD = 2'd3
    } sq_state_e;

    typedef struct packed {
        logic float_en;
        logic stat_en;
        logic ale;
        logic hlda;
    } bus_ctl_t;

    function automatic logic is_running(input sq_state_e s);
        return s == SQ_RUN;
    endfunction

endpackage

// File: rtl/bs_sync.sv
module bs_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             sys_rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (sys_rst) chain[0] <= '0;
                    else         chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (sys_rst) chain[g] <= '0;
                    else         chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/bs_width_qual.sv
module bs_width_qual #(
    parameter int MIN_HIGH = 4
) (
    input  logic clk,
    input  logic sys_rst,
    input  logic level,
    output logic wide
);
    localparam int CW = $clog2(MIN_HIGH + 2);
    localparam logic [CW-1:0] TOP = CW'(MIN_HIGH + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (sys_rst)      cnt_q <= '0;
        else if (!level)  cnt_q <= '0;
        else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end

    assign wide = (cnt_q == TOP);

    // R2
    short_ignored_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (!level && !wide) |=> !wide);
endmodule

// File: rtl/bs_nmi_gate.sv
module bs_nmi_gate (
    input  logic clk,
    input  logic sys_rst,
    input  logic nmi_s,
    input  logic open_win,
    input  logic clr,
    input  logic ack,
    output logic pend
);
    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise = nmi_s & ~prev_q;

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= nmi_s;
            if (clr)                  pend_q <= 1'b0;
            else if (rise && open_win) pend_q <= 1'b1;
            else if (ack)             pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;

    // R6
    pend_holds_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (pend_q && !ack && !clr) |=> pend_q);

    // R5
    blind_drop_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (!pend_q && !open_win) |=> !pend_q);
endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
    import boot_seq_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          MIN_HIGH    = 4,
    parameter int          INIT_LEN    = 10,
    parameter int          NMI_BLIND   = 2,
    parameter int          ADDR_W      = 20,
    parameter logic [19:0] RESET_VEC   = 20'hFFFF0
) (
    input  logic              clk,
    input  logic              sys_rst,
    input  logic              reset_pin,
    input  logic              nmi_pin,
    input  logic              nmi_ack,
    input  logic              hold_req,
    input  logic              core_ale,
    input  logic              core_hlda,
    output logic              core_run,
    output logic              fetch_go,
    output logic [ADDR_W-1:0] start_addr,
    output logic              nmi_req,
    output logic              bus_float,
    output logic              stat_en,
    output logic              ale,
    output logic              hlda
);
    localparam int IC_W = $clog2(INIT_LEN + 1);
    localparam logic [IC_W-1:0] IC_LAST  = IC_W'(INIT_LEN - 1);
    localparam logic [IC_W-1:0] IC_BLIND = IC_W'(NMI_BLIND);

    logic [1:0] pins_s;
    logic       rst_s, nmi_s, wide;

    sq_state_e      st_q, st_d;
    logic [IC_W-1:0] ic_q, ic_d;
    logic           qual_q, qual_d;
    logic           go_q, go_d;
    logic           stat1_q;
    logic           open_win;
    bus_ctl_t       bus;

    bs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
        .clk(clk), .sys_rst(sys_rst),
        .din({nmi_pin, reset_pin}), .dout(pins_s)
    );
    assign rst_s = pins_s[0];
    assign nmi_s = pins_s[1];

    bs_width_qual #(.MIN_HIGH(MIN_HIGH)) i_qual (
        .clk(clk), .sys_rst(sys_rst), .level(rst_s), .wide(wide)
    );

    assign open_win = (st_q == SQ_RUN) || (st_q == SQ_HOLD) ||
                      ((st_q == SQ_INIT) && (ic_q >= IC_BLIND));

    bs_nmi_gate i_nmi (
        .clk(clk), .sys_rst(sys_rst), .nmi_s(nmi_s), .open_win(open_win),
        .clr(st_q == SQ_HALT), .ack(nmi_ack), .pend(nmi_req)
    );

    always_comb begin
        st_d   = st_q;
        ic_d   = ic_q;
        qual_d = qual_q;
        go_d   = 1'b0;
        unique case (st_q)
            SQ_RUN: begin
                if (wide) begin
                    st_d   = SQ_HALT;
                    qual_d = 1'b1;
                end
            end
            SQ_HALT: begin
                if (wide) qual_d = 1'b1;
                if (!rst_s && qual_q) begin
                    st_d   = SQ_INIT;
                    ic_d   = '0;
                    qual_d = 1'b0;
                end
            end
            SQ_INIT: begin
                if (wide) begin
                    st_d   = SQ_HALT;
                    qual_d = 1'b1;
                end else if (ic_q == IC_LAST) begin
                    if (hold_req) st_d = SQ_HOLD;
                    else begin
                        st_d = SQ_RUN;
                        go_d = 1'b1;
                    end
                end else begin
                    ic_d = ic_q + 1'b1;
                end
            end
            SQ_HOLD: begin
                if (wide) begin
                    st_d   = SQ_HALT;
                    qual_d = 1'b1;
                end else if (!hold_req) begin
                    st_d = SQ_RUN;
                    go_d = 1'b1;
                end
            end
            default: st_d = SQ_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            st_q    <= SQ_HALT;
            ic_q    <= '0;
            qual_q  <= 1'b0;
            go_q    <= 1'b0;
            stat1_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            ic_q    <= ic_d;
            qual_q  <= qual_d;
            go_q    <= go_d;
            stat1_q <= (st_q == SQ_RUN) && wide;
        end
    end

    always_comb begin
        bus.float_en = !is_running(st_q);
        bus.stat_en  = is_running(st_q) || stat1_q;
        bus.ale      = is_running(st_q) && core_ale;
        bus.hlda     = (st_q == SQ_HOLD) || (is_running(st_q) && core_hlda);
    end

    assign core_run   = is_running(st_q);
    assign fetch_go   = go_q;
    assign start_addr = ADDR_W'(RESET_VEC);
    assign bus_float  = bus.float_en;
    assign stat_en    = bus.stat_en;
    assign ale        = bus.ale;
    assign hlda       = bus.hlda;

    // R3
    halt_on_wide_chk: assert property (@(posedge clk) disable iff (sys_rst)
        wide |=> !core_run);

    // R4
    go_in_run_chk: assert property (@(posedge clk) disable iff (sys_rst)
        fetch_go |-> core_run);

    // R4
    init_bound_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (st_q == SQ_INIT) |-> (ic_q <= IC_LAST));

    // R8
    ale_quiet_chk: assert property (@(posedge clk) disable iff (sys_rst)
        bus_float |-> !ale);

    // R7
    stat_once_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (stat1_q && !core_run) |=> !stat_en || core_run);

    // R9
    hold_grant_chk: assert property (@(posedge clk) disable iff (sys_rst)
        (st_q == SQ_HOLD && hold_req && !wide) |=> hlda);
endmodule

// File: tb/test_boot_sequencer.sv
module test_boot_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;
    localparam int MINH = 4;
    localparam int ILEN = 10;
    localparam int BLIND = 2;

    logic clk = 1'b0;
    logic sys_rst = 1'b1, reset_pin = 1'b0, nmi_pin = 1'b0, nmi_ack = 1'b0;
    logic hold_req = 1'b0, core_ale = 1'b0, core_hlda = 1'b0;
    logic core_run, fetch_go, nmi_req, bus_float, stat_en, ale, hlda;
    logic [19:0] start_addr;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_sequencer i_boot_sequencer (
        .clk(clk), .sys_rst(sys_rst), .reset_pin(reset_pin), .nmi_pin(nmi_pin),
        .nmi_ack(nmi_ack), .hold_req(hold_req), .core_ale(core_ale),
        .core_hlda(core_hlda), .core_run(core_run), .fetch_go(fetch_go),
        .start_addr(start_addr), .nmi_req(nmi_req), .bus_float(bus_float),
        .stat_en(stat_en), .ale(ale), .hlda(hlda)
    );

    // Behavioural reference: 0 run, 1 held, 2 init, 3 hold
    bit rq[$];
    bit nq[$];
    int m_st = 1, m_hi = 0, m_ic = 0;
    bit m_qual = 0, m_nd = 0, m_pend = 0, m_stat1 = 0, m_go = 0;

    always @(posedge clk) begin
        if (sys_rst) begin
            rq = {}; nq = {};
            for (int i = 0; i < SYNC; i++) begin rq.push_back(0); nq.push_back(0); end
            m_st = 1; m_hi = 0; m_ic = 0; m_qual = 0; m_nd = 0;
            m_pend = 0; m_stat1 = 0; m_go = 0;
        end else begin
            bit rs, ns, w, opn, rise;
            int st_n;
            rs = rq[SYNC-1];
            ns = nq[SYNC-1];
            w = (m_hi > MINH);
            opn = (m_st == 0) || (m_st == 3) || (m_st == 2 && m_ic >= BLIND);
            rise = ns && !m_nd;
            if (m_st == 1) m_pend = 0;
            else if (rise && opn) m_pend = 1;
            else if (nmi_ack) m_pend = 0;
            m_nd = ns;
            m_stat1 = (m_st == 0) && w;
            m_go = 0;
            st_n = m_st;
            if (m_st == 1) begin
                if (!rs && m_qual) begin st_n = 2; m_ic = 0; m_qual = 0; end
                else if (w) m_qual = 1;
            end else if (w) begin
                st_n = 1; m_qual = 1;
            end else if (m_st == 2) begin
                if (m_ic == ILEN-1) begin
                    if (hold_req) st_n = 3; else begin st_n = 0; m_go = 1; end
                end else m_ic++;
            end else if (m_st == 3 && !hold_req) begin
                st_n = 0; m_go = 1;
            end
            m_st = st_n;
            m_hi = rs ? ((m_hi > MINH) ? MINH+1 : m_hi+1) : 0;
            rq.push_front(reset_pin); void'(rq.pop_back());
            nq.push_front(nmi_pin);   void'(nq.pop_back());
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit run;
        run = (m_st == 0);
        check("R1 R3", "core_run", 32'(core_run), 32'(run));
        check("R7", "bus_float", 32'(bus_float), 32'(!run));
        check("R7", "stat_en", 32'(stat_en), 32'(run || m_stat1));
        check("R8", "ale", 32'(ale), 32'(run && core_ale));
        check("R8 R9", "hlda", 32'(hlda), 32'((m_st == 3) || (run && core_hlda)));
        check("R4", "fetch_go", 32'(fetch_go), 32'(m_go));
        check("R5 R6", "nmi_req", 32'(nmi_req), 32'(m_pend));
        check("R4", "start_addr", 32'(start_addr), 32'h000FFFF0);
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic rst_pulse(int width);
        reset_pin = 1'b1; step(width); reset_pin = 1'b0;
    endtask

    initial begin
        step(3);
        sys_rst = 1'b0;
        // R10 held state after power-on reset
        check("R10", "core_run after sys_rst", 32'(core_run), 32'd0);
        check("R10", "bus_float after sys_rst", 32'(bus_float), 32'd1);
        step(5);
        rst_pulse(MINH); step(15);
        check("R2", "short pulse leaves block waiting", 32'(core_run), 32'd0);
        rst_pulse(MINH + 4); step(20);
        check("R4", "running after valid reset", 32'(core_run), 32'd1);
        for (int i = 0; i < 6; i++) begin
            core_ale = i[0]; core_hlda = i[1]; step(1);
        end
        core_ale = 0; core_hlda = 0;
        // R2 glitch while running
        rst_pulse(MINH);
        for (int i = 0; i < 10; i++) begin
            step(1);
            check("R2", "glitch keeps core running", 32'(core_run), 32'd1);
        end
        // R3 minimum valid width while running, ALE requested during reset
        core_ale = 1; rst_pulse(MINH + 1); step(25); core_ale = 0;
        // R5 sweep request edge around the blind window
        for (int d = 0; d < 8; d++) begin
            rst_pulse(MINH + 3);
            step(d);
            nmi_pin = 1; step(3); nmi_pin = 0;
            step(20);
            nmi_ack = 1; step(1); nmi_ack = 0; step(2);
        end
        // R5 level held across reset end never latches
        nmi_pin = 1; rst_pulse(MINH + 2); step(25); nmi_pin = 0; step(3);
        // R6 request in run, edge coincident with ack
        nmi_pin = 1; step(4); nmi_pin = 0; step(3);
        nmi_pin = 1; step(SYNC); nmi_ack = 1; step(1); nmi_ack = 0; nmi_pin = 0; step(4);
        nmi_ack = 1; step(1); nmi_ack = 0; step(2);
        // R6 pending cleared by reset
        nmi_pin = 1; step(5); nmi_pin = 0; rst_pulse(MINH + 2); step(20);
        // R9 hold active at end of init
        hold_req = 1; rst_pulse(MINH + 2); step(22); hold_req = 0; step(5);
        // R9 hold raised partway through init
        rst_pulse(MINH + 2); step(SYNC + 5); hold_req = 1; step(12); hold_req = 0; step(5);
        // R3 reset again during init
        rst_pulse(MINH + 2); step(SYNC + 4); rst_pulse(MINH + 3); step(25);
        // R3 reset during hold
        hold_req = 1; rst_pulse(MINH + 2); step(20); rst_pulse(MINH + 1); hold_req = 0; step(25);
        check("R4", "running at end", 32'(core_run), 32'd1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule